// File: doc/BRIEF.md
# Shared-Term Programmable AND-OR Array

This block is a programmable sum-of-products plane. It has 38 input signals. From each one it builds a true literal and an inverted literal. A configurable AND plane combines those literals into a pool of 64 product terms. A configurable OR plane then lets each of 50 sum outputs collect any subset of that pool. No product term is reserved for a particular output, so one term can feed many sums at once.

Of the 50 sums, 48 go to twelve logic cells in groups of four. The remaining two sums and the first three product terms leave the block directly as global control signals. The configuration is written one product-term row at a time, while the array is idle. Each row carries the row's AND selection and its OR fan-out.

Once software signals that loading is complete, the array evaluates every cycle. The result is captured in output registers.

Top module: `pla_array`

## Requirements
- R1: Literal column 2i is input i and column 2i+1 is its inverse; product term r is the AND of the literal columns whose bit is set in AND mask r (bit c selects column c).
- R2: A product term whose AND mask is all zero evaluates to 1.
- R3: A product term that selects both the true and the inverted column of one input evaluates to 0.
- R4: Sum j is the OR of every product term r whose OR mask bit j is set; a sum with no selected term is 0.
- R5: Sums 0 to 47 appear on cell_sum, and cell k owns bits 4k+3..4k. Sum 48 appears on glb_sum[0] and sum 49 on glb_sum[1].
- R6: Product terms 0, 1 and 2 appear on glb_pt[0], glb_pt[1] and glb_pt[2].
- R7: When cfg_we is high at a clock edge, row cfg_row stores cfg_and and cfg_or, and out_valid is low after that edge.
- R8: cfg_done at an edge raises out_valid unless cfg_we is high in the same cycle; in that case the write wins and out_valid stays low.
- R9: Outputs are registered. After an edge with out_valid high, they show the function of the inputs present at that edge; while out_valid is low, every output is 0.
- R10: Synchronous reset clears all configuration rows, out_valid and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 6 | Product-term row index |
| cfg_and | input | 76 | AND mask for the row, one bit per literal column |
| cfg_or | input | 50 | OR fan-out for the row, one bit per sum |
| cfg_done | input | 1 | Marks configuration complete |
| in_sig | input | 38 | Array input signals |
| cell_sum | output | 48 | Registered sums of the twelve logic cells |
| glb_sum | output | 2 | Registered global sums |
| glb_pt | output | 3 | Registered global product terms |
| out_valid | output | 1 | Outputs carry array results |

## Verification
A row write and the completion strobe can arrive in the same cycle. Their effects conflict: one marks the array busy and the other marks it ready. The bench raises cfg_we and cfg_done together on one edge. It then requires out_valid to stay low and every output to read zero, even with inputs that would drive sums high. After that it sends a lone cfg_done and confirms that the freshly written row takes part in evaluation.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned PLA_N_IN      = 38;
  localparam int unsigned PLA_N_PT      = 64;
  localparam int unsigned PLA_N_SUM     = 50;
  localparam int unsigned PLA_N_CELL    = 12;
  localparam int unsigned PLA_SUM_CELL  = 4;
  localparam int unsigned PLA_N_GPT     = 3;
endpackage

// File: rtl/pla_literals.sv
module pla_literals #(
  parameter int unsigned N_IN  = pla_pkg::PLA_N_IN,
  localparam int unsigned N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]  in_sig,
  output logic [N_LIT-1:0] lit
);
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = in_sig[i];
    assign lit[2*i+1] = ~in_sig[i];
  end
endmodule

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned N_LIT = 2 * pla_pkg::PLA_N_IN,
  parameter int unsigned N_PT  = pla_pkg::PLA_N_PT,
  parameter int unsigned N_SUM = pla_pkg::PLA_N_SUM,
  localparam int unsigned ROW_W = $clog2(N_PT)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [ROW_W-1:0]                cfg_row,
  input  logic [N_LIT-1:0]                cfg_and,
  input  logic [N_SUM-1:0]                cfg_or,
  output logic [N_PT-1:0][N_LIT-1:0]      and_mask,
  output logic [N_PT-1:0][N_SUM-1:0]      or_mask
);
  for (genvar r = 0; r < N_PT; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        and_mask[r] <= '0;
        or_mask[r]  <= '0;
      end else if (cfg_we && cfg_row == ROW_W'(r)) begin
        and_mask[r] <= cfg_and;
        or_mask[r]  <= cfg_or;
      end
    end
  end

  // R7
  row_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (and_mask[$past(cfg_row)] == $past(cfg_and)) &&
               (or_mask[$past(cfg_row)] == $past(cfg_or)));

  // R10
  cfg_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (and_mask == '0) && (or_mask == '0));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_LIT = 2 * pla_pkg::PLA_N_IN,
  parameter int unsigned N_PT  = pla_pkg::PLA_N_PT
) (
  input  logic [N_LIT-1:0]             lit,
  input  logic [N_PT-1:0][N_LIT-1:0]   and_mask,
  output logic [N_PT-1:0]              pt
);
  for (genvar r = 0; r < N_PT; r++) begin : g_pt
    assign pt[r] = &(lit | ~and_mask[r]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_PT  = pla_pkg::PLA_N_PT,
  parameter int unsigned N_SUM = pla_pkg::PLA_N_SUM
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_PT-1:0]              pt,
  input  logic [N_PT-1:0][N_SUM-1:0]   or_mask,
  output logic [N_SUM-1:0]             sum
);
  for (genvar j = 0; j < N_SUM; j++) begin : g_sum
    logic [N_PT-1:0] sel;
    for (genvar r = 0; r < N_PT; r++) begin : g_col
      assign sel[r] = pt[r] & or_mask[r][j];
    end
    assign sum[j] = |sel;
  end

  // R4
  no_term_chk: assert property (@(posedge clk) disable iff (rst)
    (pt == '0) |-> (sum == '0));
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int unsigned N_IN     = pla_pkg::PLA_N_IN,
  parameter int unsigned N_PT     = pla_pkg::PLA_N_PT,
  parameter int unsigned N_SUM    = pla_pkg::PLA_N_SUM,
  parameter int unsigned N_CELL   = pla_pkg::PLA_N_CELL,
  parameter int unsigned SUM_CELL = pla_pkg::PLA_SUM_CELL,
  parameter int unsigned N_GPT    = pla_pkg::PLA_N_GPT,
  localparam int unsigned N_LIT   = 2 * N_IN,
  localparam int unsigned ROW_W   = $clog2(N_PT),
  localparam int unsigned N_CSUM  = N_CELL * SUM_CELL,
  localparam int unsigned N_GSUM  = N_SUM - N_CSUM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [ROW_W-1:0]   cfg_row,
  input  logic [N_LIT-1:0]   cfg_and,
  input  logic [N_SUM-1:0]   cfg_or,
  input  logic               cfg_done,
  input  logic [N_IN-1:0]    in_sig,
  output logic [N_CSUM-1:0]  cell_sum,
  output logic [N_GSUM-1:0]  glb_sum,
  output logic [N_GPT-1:0]   glb_pt,
  output logic               out_valid
);
  logic [N_LIT-1:0]           lit;
  logic [N_PT-1:0][N_LIT-1:0] and_mask;
  logic [N_PT-1:0][N_SUM-1:0] or_mask;
  logic [N_PT-1:0]            pt;
  logic [N_SUM-1:0]           sum;
  logic                       valid_d;

  pla_literals #(.N_IN(N_IN)) u_lit (.in_sig(in_sig), .lit(lit));

  pla_cfg_store #(.N_LIT(N_LIT), .N_PT(N_PT), .N_SUM(N_SUM)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_and(cfg_and), .cfg_or(cfg_or),
    .and_mask(and_mask), .or_mask(or_mask)
  );

  pla_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_and (
    .lit(lit), .and_mask(and_mask), .pt(pt)
  );

  pla_or_plane #(.N_PT(N_PT), .N_SUM(N_SUM)) u_or (
    .clk(clk), .rst(rst), .pt(pt), .or_mask(or_mask), .sum(sum)
  );

  always_comb begin
    if (cfg_we)        valid_d = 1'b0;
    else if (cfg_done) valid_d = 1'b1;
    else               valid_d = out_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cell_sum  <= '0;
      glb_sum   <= '0;
      glb_pt    <= '0;
    end else begin
      out_valid <= valid_d;
      if (valid_d) begin
        cell_sum <= sum[N_CSUM-1:0];
        glb_sum  <= sum[N_SUM-1:N_CSUM];
        glb_pt   <= pt[N_GPT-1:0];
      end else begin
        cell_sum <= '0;
        glb_sum  <= '0;
        glb_pt   <= '0;
      end
    end
  end

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (cell_sum == '0) && (glb_sum == '0) && (glb_pt == '0));

  // R7
  we_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !out_valid);

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && !cfg_we) |=> out_valid);

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !cfg_done) |=> $stable(out_valid));
endmodule

// File: tb/pla_array_test.sv
module pla_array_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_row = '0;
  logic [75:0] cfg_and = '0;
  logic [49:0] cfg_or = '0;
  logic        cfg_done = 1'b0;
  logic [37:0] in_sig = '0;
  logic [47:0] cell_sum;
  logic [1:0]  glb_sum;
  logic [2:0]  glb_pt;
  logic        out_valid;

  int n_run = 0;
  int n_fail = 0;

  logic [75:0] m_and [64];
  logic [49:0] m_or  [64];

  always #2 clk = ~clk;

  pla_array uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_and(cfg_and), .cfg_or(cfg_or), .cfg_done(cfg_done),
    .in_sig(in_sig), .cell_sum(cell_sum), .glb_sum(glb_sum),
    .glb_pt(glb_pt), .out_valid(out_valid)
  );

  // {sum49, sum2, sum1, sum0, in[5:0]} for the directed configuration
  localparam logic [9:0] VEC [8] = '{
    10'b1000_000000, 10'b1001_000001, 10'b1000_000011, 10'b1011_000100,
    10'b1011_000111, 10'b1001_100001, 10'b1000_100000, 10'b1011_111110
  };

  function automatic logic model_pt(input int r, input logic [37:0] x);
    logic v = 1'b1;
    for (int i = 0; i < 38; i++) begin
      if (m_and[r][2*i]   && !x[i]) v = 1'b0;
      if (m_and[r][2*i+1] &&  x[i]) v = 1'b0;
    end
    return v;
  endfunction

  function automatic logic [49:0] model_sum(input logic [37:0] x);
    logic [49:0] s = '0;
    for (int r = 0; r < 64; r++)
      if (model_pt(r, x)) s = s | m_or[r];
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr_row(input int r, input logic [75:0] a, input logic [49:0] o);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 6'(r); cfg_and = a; cfg_or = o;
    m_and[r] = a; m_or[r] = o;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_done;
    @(negedge clk);
    cfg_done = 1'b1;
    tick();
    cfg_done = 1'b0;
  endtask

  task automatic clear_model;
    for (int r = 0; r < 64; r++) begin m_and[r] = '0; m_or[r] = '0; end
  endtask

  task automatic apply_cmp(input logic [37:0] x, input string req);
    logic [49:0] s;
    logic [2:0]  g;
    @(negedge clk);
    in_sig = x;
    tick();
    s = model_sum(x);
    for (int k = 0; k < 3; k++) g[k] = model_pt(k, x);
    check(req, {16'd0, glb_sum, cell_sum}, {14'd0, s});
    check({req, " R6"}, {61'd0, glb_pt}, {61'd0, g});
  endtask

  initial begin
    clear_model();
    repeat (3) tick();
    @(negedge clk);
    rst = 1'b0;
    in_sig = '1;
    tick();
    // R10 reset state
    check("R10 valid", {63'd0, out_valid}, 64'd0);
    check("R10 outputs", {11'd0, glb_pt, glb_sum, cell_sum}, 64'd0);

    // R10 R2: empty configuration, every product term is 1, every sum 0
    pulse_done();
    check("R8 done sets valid", {63'd0, out_valid}, 64'd1);
    apply_cmp('0, "R10 R2 R4 empty array");

    // directed configuration
    wr_row(0, 76'b1001, 50'b1);                     // in0 & ~in1 -> sum0
    check("R7 write clears valid", {63'd0, out_valid}, 64'd0);
    wr_row(1, 76'b1 << 4, 50'b11);                  // in2 -> sum0, sum1
    wr_row(2, '0, 50'b1 << 49);                     // empty -> sum49
    wr_row(3, 76'b11 << 10, 50'b100);               // in5 & ~in5 -> sum2
    @(negedge clk);
    in_sig = 38'h3F;
    tick();
    // R9 outputs zero while invalid
    check("R9 idle outputs", {11'd0, glb_pt, glb_sum, cell_sum}, 64'd0);

    // R8 collision: write and done together, write wins
    @(negedge clk);
    cfg_we = 1'b1; cfg_done = 1'b1; cfg_row = 6'd4;
    cfg_and = 76'b1 << 6; cfg_or = 50'b1 << 47;      // in3 -> sum47 (cell 11 bit 3)
    m_and[4] = cfg_and; m_or[4] = cfg_or;
    tick();
    cfg_we = 1'b0; cfg_done = 1'b0;
    check("R8 collision valid", {63'd0, out_valid}, 64'd0);
    check("R8 collision outputs", {11'd0, glb_pt, glb_sum, cell_sum}, 64'd0);
    pulse_done();

    // table walk: R1 R3 R4 R5 R9
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_sig = {32'd0, VEC[v][5:0]};
      tick();
      check("R1 R4 sum0", {63'd0, cell_sum[0]}, {63'd0, VEC[v][6]});
      check("R4 sum1", {63'd0, cell_sum[1]}, {63'd0, VEC[v][7]});
      check("R3 contradictory", {63'd0, cell_sum[2]}, {63'd0, VEC[v][8]});
      check("R5 glb_sum", {62'd0, glb_sum}, {62'd0, VEC[v][9], 1'b0});
      check("R5 cell 11", {63'd0, cell_sum[47]}, {63'd0, VEC[v][3]});
      check("R6 glb_pt2", {63'd0, glb_pt[2]}, 64'd1);
    end

    // random configurations against the model
    for (int c = 0; c < 5; c++) begin
      for (int r = 0; r < 64; r++) begin
        logic [75:0] a;
        logic [49:0] o;
        a = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
          & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
        if (r % 5 == 0) a = '0;
        o = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        wr_row(r, a, o);
      end
      pulse_done();
      for (int t = 0; t < 20; t++) begin
        logic [37:0] x;
        x = {$urandom, $urandom};
        apply_cmp(x, "R1 R4 R5 random");
      end
    end

    // R10 reset after use clears the array
    @(negedge clk);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    clear_model();
    check("R10 valid after reset", {63'd0, out_valid}, 64'd0);
    pulse_done();
    apply_cmp(38'h2A_5555_AAAA, "R10 R2 cleared");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule